// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block sequences analog-to-digital conversions over a bank of sixteen input channels on behalf of two independent software request sources. Each source owns a 16-bit channel-select mask, a 16-bit averaging mask and a control register. Writing the start bit of a source's control register queues that source. The sequencer then walks the selected channels from the lowest index upward and drives an external sample port for each channel. For every channel it stores one 10-bit code in a shared result bank.

The converter itself sits outside the block. The block raises a one-cycle request carrying a channel index. The converter answers a fixed number of cycles later with a one-cycle valid strobe and a 10-bit code. A channel whose averaging bit is set is sampled four times in a row, and the truncated mean of the four codes is stored.

Completion shows in each source's control register as busy clear with end-of-conversion set. It also sets a per-source bit in two independent interrupt status registers. Each of those registers drives its own interrupt output through its own mask register. Software reaches everything over a byte-wide register bus that has a write strobe and a combinational read port.

Top module: `adc_seq`

## Requirements
- R1: The channel-select and averaging masks are read/write byte pairs, with the low byte at the lower address. Source 1 uses select 0x06/0x07 and average 0x08/0x09. Source 2 uses select 0x0A/0x0B and average 0x0C/0x0D.
- R2: Writing a byte with bit 5 set to a control register (0x12 for source 1, 0x13 for source 2) starts that source. From the next cycle, bit 0 (busy) of that register reads 1 until the source completes.
- R3: The selected channels are converted in ascending index order. Each sample is requested by a `smp_req` pulse that lasts exactly one cycle, with the channel index on `smp_chan`. A channel whose averaging bit is clear gets one sample.
- R4: A channel whose averaging bit is set gets four consecutive samples, and the stored code is floor(sum of the four codes / 4).
- R5: Channel i's result is stored left-aligned in a 16-bit pair. Address 0x37+2i is the low byte, holding code bits 1:0 in bits 7:6 with bits 5:0 zero. Address 0x38+2i is the high byte, holding code bits 9:2.
- R6: Completion of a source clears busy and sets bit 1 (end-of-conversion) of its control register in the same cycle. A new accepted start clears end-of-conversion. Busy and end-of-conversion are never set together.
- R7: A start written to a source that is already busy is ignored. It triggers no further samples and no second completion.
- R8: If both sources are pending, source 1 is served completely before source 2. Each source signals completion only when its own last channel has been stored.
- R9: There are two interrupt status registers: line A at 0x61 and line B at 0x63. Bit 1 records a source-1 completion and bit 2 a source-2 completion. Bit 0, the real-time path, always reads 0. Completion sets the bit in both registers, and writing 1 to a bit clears it in that register only.
- R10: Each line has a mask register (line A at 0x62, line B at 0x64). `irq_a`/`irq_b` is high when a status bit of that line is set and its mask bit is clear. Setting a mask bit silences it.
- R11: After reset, all masks, control bits, status bits and results read 0, except the interrupt masks, which read 0x07. Both interrupt outputs are low.
- R12: A start with an empty select mask completes without issuing any sample request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| smp_req | output | 1 | One-cycle sample request to the converter |
| smp_chan | output | 4 | Channel index of the request |
| smp_valid | input | 1 | One-cycle strobe: converter code is valid |
| smp_code | input | 10 | Converter code |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
After a request, a code is due from the bench's converter model four cycles later: the model counts three cycles down and then registers the strobe. A stored result is only due once the source's control register reads busy clear with end-of-conversion set, so the bench polls that register and reads the result bank only afterwards. A monitor on the sample port pops the expected channel at the edge where each request is seen, so both the ascending order and the priority of source 1 over source 2 are checked as the requests happen. Register effects are due one edge after a write; the bench drives on the falling edge and samples one nanosecond later, away from the active edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_N = 16;
    localparam int CH_W = 4;
    localparam int SRC_N = 2;

    localparam logic [7:0] A_SEL1_LO = 8'h06;
    localparam logic [7:0] A_SEL1_HI = 8'h07;
    localparam logic [7:0] A_AVG1_LO = 8'h08;
    localparam logic [7:0] A_AVG1_HI = 8'h09;
    localparam logic [7:0] A_SEL2_LO = 8'h0A;
    localparam logic [7:0] A_SEL2_HI = 8'h0B;
    localparam logic [7:0] A_AVG2_LO = 8'h0C;
    localparam logic [7:0] A_AVG2_HI = 8'h0D;
    localparam logic [7:0] A_CTRL1   = 8'h12;
    localparam logic [7:0] A_CTRL2   = 8'h13;
    localparam logic [7:0] A_RES     = 8'h37;
    localparam logic [7:0] A_STA_A   = 8'h61;
    localparam logic [7:0] A_MSK_A   = 8'h62;
    localparam logic [7:0] A_STA_B   = 8'h63;
    localparam logic [7:0] A_MSK_B   = 8'h64;

    localparam int BIT_BUSY  = 0;
    localparam int BIT_EOC   = 1;
    localparam int BIT_START = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_REQ,
        ST_WAIT,
        ST_STORE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  busy,
    input  logic [CH_N-1:0]   sel1,
    input  logic [CH_N-1:0]   sel2,
    input  logic [CH_N-1:0]   avg1,
    input  logic [CH_N-1:0]   avg2,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_chan,
    output logic              res_we,
    output logic [CH_W-1:0]   res_chan,
    output logic [CODE_W-1:0] res_code,
    output logic              done,
    output logic              done_src
);
    localparam int ACC_W = CODE_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;
    localparam logic [CNT_W-1:0] SAMP_AVG = CNT_W'(1 << AVG_LOG2);

    seq_state_t state_q, state_d;

    logic             src_q;
    logic [CH_N-1:0]  remain_q;
    logic [CH_N-1:0]  avg_q;
    logic [CH_W-1:0]  chan_q;
    logic             is_avg_q;
    logic [CNT_W-1:0] left_q;
    logic [ACC_W-1:0] acc_q;

    logic [CH_W-1:0]  pick_idx;
    logic             pick_any;

    adc_seq_pick #(.N(CH_N), .W(CH_W)) u_pick (
        .vec (remain_q),
        .idx (pick_idx),
        .any (pick_any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|busy) state_d = ST_PICK;
            ST_PICK:  state_d = pick_any ? ST_REQ : ST_DONE;
            ST_REQ:   state_d = ST_WAIT;
            ST_WAIT:  if (smp_valid) state_d = (left_q == CNT_W'(1)) ? ST_STORE : ST_REQ;
            ST_STORE: state_d = ST_PICK;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= 1'b0;
            remain_q <= '0;
            avg_q    <= '0;
            chan_q   <= '0;
            is_avg_q <= 1'b0;
            left_q   <= '0;
            acc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (busy[0]) begin
                        src_q    <= 1'b0;
                        remain_q <= sel1;
                        avg_q    <= avg1;
                    end else if (busy[1]) begin
                        src_q    <= 1'b1;
                        remain_q <= sel2;
                        avg_q    <= avg2;
                    end
                end
                ST_PICK: begin
                    if (pick_any) begin
                        chan_q             <= pick_idx;
                        remain_q[pick_idx] <= 1'b0;
                        is_avg_q           <= avg_q[pick_idx];
                        left_q             <= avg_q[pick_idx] ? SAMP_AVG : CNT_W'(1);
                        acc_q              <= '0;
                    end
                end
                ST_WAIT: begin
                    if (smp_valid) begin
                        acc_q  <= acc_q + ACC_W'(smp_code);
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        smp_req  = (state_q == ST_REQ);
        smp_chan = chan_q;
        res_we   = (state_q == ST_STORE);
        res_chan = chan_q;
        res_code = is_avg_q ? acc_q[ACC_W-1:AVG_LOG2] : acc_q[CODE_W-1:0];
        done     = (state_q == ST_DONE);
        done_src = src_q;
    end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              done,
    input  logic              done_src,
    input  logic              res_we,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [CODE_W-1:0] res_code,
    output logic [CH_N-1:0]   sel1,
    output logic [CH_N-1:0]   sel2,
    output logic [CH_N-1:0]   avg1,
    output logic [CH_N-1:0]   avg2,
    output logic [SRC_N-1:0]  busy,
    output logic [SRC_N-1:0]  eoc,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int PAD_W = 16 - CODE_W;
    localparam logic [7:0] RES_END = A_RES + 8'(2 * CH_N);

    logic [2:0]  sta_a, sta_b, msk_a, msk_b;
    logic [15:0] res_q [CH_N];
    logic [2:0]  set_bits, clr_a, clr_b;
    logic [7:0]  res_off;

    assign set_bits = done ? (done_src ? 3'b100 : 3'b010) : 3'b000;
    assign clr_a    = (bus_we && bus_addr == A_STA_A) ? bus_wdata[2:0] : 3'b000;
    assign clr_b    = (bus_we && bus_addr == A_STA_B) ? bus_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel1 <= '0; sel2 <= '0; avg1 <= '0; avg2 <= '0;
            msk_a <= 3'b111; msk_b <= 3'b111;
        end else if (bus_we) begin
            case (bus_addr)
                A_SEL1_LO: sel1[7:0]  <= bus_wdata;
                A_SEL1_HI: sel1[15:8] <= bus_wdata;
                A_AVG1_LO: avg1[7:0]  <= bus_wdata;
                A_AVG1_HI: avg1[15:8] <= bus_wdata;
                A_SEL2_LO: sel2[7:0]  <= bus_wdata;
                A_SEL2_HI: sel2[15:8] <= bus_wdata;
                A_AVG2_LO: avg2[7:0]  <= bus_wdata;
                A_AVG2_HI: avg2[15:8] <= bus_wdata;
                A_MSK_A:   msk_a      <= bus_wdata[2:0];
                A_MSK_B:   msk_b      <= bus_wdata[2:0];
                default: ;
            endcase
        end
    end

    // busy / end-of-conversion per source, interrupt status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= '0;
            eoc   <= '0;
            sta_a <= '0;
            sta_b <= '0;
        end else begin
            for (int s = 0; s < SRC_N; s++) begin
                if (done && done_src == 1'(s)) begin
                    busy[s] <= 1'b0;
                    eoc[s]  <= 1'b1;
                end else if (bus_we && bus_addr == A_CTRL1 + 8'(s)
                             && bus_wdata[BIT_START] && !busy[s]) begin
                    busy[s] <= 1'b1;
                    eoc[s]  <= 1'b0;
                end
            end
            sta_a <= (sta_a & ~clr_a) | set_bits;
            sta_b <= (sta_b & ~clr_b) | set_bits;
        end
    end

    // result bank, left-aligned codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH_N; c++) res_q[c] <= '0;
        end else if (res_we) begin
            res_q[res_chan] <= {res_code, {PAD_W{1'b0}}};
        end
    end

    assign res_off = bus_addr - A_RES;

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr >= A_RES && bus_addr < RES_END) begin
            bus_rdata = res_off[0] ? res_q[res_off[CH_W:1]][15:8]
                                   : res_q[res_off[CH_W:1]][7:0];
        end else begin
            case (bus_addr)
                A_SEL1_LO: bus_rdata = sel1[7:0];
                A_SEL1_HI: bus_rdata = sel1[15:8];
                A_AVG1_LO: bus_rdata = avg1[7:0];
                A_AVG1_HI: bus_rdata = avg1[15:8];
                A_SEL2_LO: bus_rdata = sel2[7:0];
                A_SEL2_HI: bus_rdata = sel2[15:8];
                A_AVG2_LO: bus_rdata = avg2[7:0];
                A_AVG2_HI: bus_rdata = avg2[15:8];
                A_CTRL1:   bus_rdata = {6'b0, eoc[0], busy[0]};
                A_CTRL2:   bus_rdata = {6'b0, eoc[1], busy[1]};
                A_STA_A:   bus_rdata = {5'b0, sta_a};
                A_MSK_A:   bus_rdata = {5'b0, msk_a};
                A_STA_B:   bus_rdata = {5'b0, sta_b};
                A_MSK_B:   bus_rdata = {5'b0, msk_b};
                default:   bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq_a = |(sta_a & ~msk_a);
    assign irq_b = |(sta_b & ~msk_b);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_chan,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic              irq_a,
    output logic              irq_b
);
    logic [CH_N-1:0]   sel1_w, sel2_w, avg1_w, avg2_w;
    logic [SRC_N-1:0]  busy_w, eoc_w;
    logic              done_w, done_src_w, res_we_w;
    logic [CH_W-1:0]   res_chan_w;
    logic [CODE_W-1:0] res_code_w;

    adc_seq_regs #(.CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done_w),
        .done_src  (done_src_w),
        .res_we    (res_we_w),
        .res_chan  (res_chan_w),
        .res_code  (res_code_w),
        .sel1      (sel1_w),
        .sel2      (sel2_w),
        .avg1      (avg1_w),
        .avg2      (avg2_w),
        .busy      (busy_w),
        .eoc       (eoc_w),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    adc_seq_fsm #(.CODE_W(CODE_W), .AVG_LOG2(AVG_LOG2)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_w),
        .sel1      (sel1_w),
        .sel2      (sel2_w),
        .avg1      (avg1_w),
        .avg2      (avg2_w),
        .smp_valid (smp_valid),
        .smp_code  (smp_code),
        .smp_req   (smp_req),
        .smp_chan  (smp_chan),
        .res_we    (res_we_w),
        .res_chan  (res_chan_w),
        .res_code  (res_code_w),
        .done      (done_w),
        .done_src  (done_src_w)
    );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [7:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             smp_req,
    input logic             irq_a,
    input logic [SRC_N-1:0] busy_w,
    input logic [SRC_N-1:0] eoc_w
);
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    assert_req_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> (busy_w != '0));

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL1 && bus_wdata[BIT_START]) |=> busy_w[0]);

    assert_busy_eoc_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_w[0] && eoc_w[0]) && !(busy_w[1] && eoc_w[1]));

    assert_finish_sets_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w[0]) |-> eoc_w[0]);

    assert_mask_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MSK_A && bus_wdata[2:0] == 3'b111) |=> !irq_a);
endmodule

bind adc_seq adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .smp_req   (smp_req),
    .irq_a     (irq_a),
    .busy_w    (busy_w),
    .eoc_w     (eoc_w)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       smp_req;
    logic [3:0] smp_chan;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_code = 10'h0;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit force_max = 0;

    int samp_cnt [16];
    int pred_cnt [16];
    int total_samples = 0;
    int cd = 0;
    logic [9:0] code_r;

    int    ord_q[$];
    int    exp_ch_q[$];
    int    exp_code_q[$];
    string exp_tag_q[$];

    always #2 clk = ~clk;

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_req(smp_req),
        .smp_chan(smp_chan), .smp_valid(smp_valid), .smp_code(smp_code),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [9:0] code_of(int ch, int n);
        if (force_max) return 10'h3FF;
        return 10'((ch * 97 + n * 131 + 5) % 1024);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model and order monitor (R3, R8)
    always @(posedge clk) begin
        smp_valid <= 1'b0;
        if (smp_req) begin
            checks++;
            if (ord_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected request actual=%0d expected=none", smp_chan);
            end else begin
                int e;
                e = ord_q.pop_front();
                if (e != int'(smp_chan)) begin
                    errors++;
                    $display("FAIL R3/R8 channel order actual=%0d expected=%0d", smp_chan, e);
                end
            end
            code_r <= code_of(int'(smp_chan), samp_cnt[smp_chan]);
            samp_cnt[smp_chan] <= samp_cnt[smp_chan] + 1;
            total_samples <= total_samples + 1;
            cd <= LAT;
        end else if (cd > 0) begin
            cd <= cd - 1;
            if (cd == 1) begin
                smp_valid <= 1'b1;
                smp_code  <= code_r;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: push expected results and request order
    task automatic plan(input logic [15:0] sel, input logic [15:0] avg, input string tag);
        for (int c = 0; c < 16; c++) begin
            if (sel[c]) begin
                int n;
                int sum;
                n = avg[c] ? 4 : 1;
                sum = 0;
                for (int k = 0; k < n; k++) begin
                    sum += int'(code_of(c, pred_cnt[c]));
                    pred_cnt[c]++;
                    ord_q.push_back(c);
                end
                exp_ch_q.push_back(c);
                exp_code_q.push_back(avg[c] ? sum / 4 : sum);
                exp_tag_q.push_back(tag);
            end
        end
    endtask

    task automatic wait_done(input logic [7:0] ctrl, input string tag);
        logic [7:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(ctrl, v);
            if (v[1:0] == 2'b10) return;
        end
        chk({tag, " completion"}, int'(v), 2);
    endtask

    // monitor: read back stored results
    task automatic drain_results();
        while (exp_ch_q.size() > 0) begin
            int c, e;
            string t;
            logic [7:0] lo, hi;
            c = exp_ch_q.pop_front();
            e = exp_code_q.pop_front();
            t = exp_tag_q.pop_front();
            rd(8'h37 + 8'(2 * c), lo);
            rd(8'h38 + 8'(2 * c), hi);
            chk({t, " R5 result code"}, int'({hi, lo} >> 6), e);
            chk({t, " R5 low byte pad"}, int'(lo[5:0]), 0);
        end
    endtask

    task automatic set_src(input int s, input logic [15:0] sel, input logic [15:0] avg);
        logic [7:0] b;
        b = (s == 1) ? 8'h06 : 8'h0A;
        wr(b, sel[7:0]);      wr(b + 8'd1, sel[15:8]);
        wr(b + 8'd2, avg[7:0]); wr(b + 8'd3, avg[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int base;
        for (int c = 0; c < 16; c++) begin samp_cnt[c] = 0; pred_cnt[c] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(8'h12, v); chk("R11 ctrl1", int'(v), 0);
        rd(8'h13, v); chk("R11 ctrl2", int'(v), 0);
        rd(8'h62, v); chk("R11 mask A", int'(v), 7);
        rd(8'h64, v); chk("R11 mask B", int'(v), 7);
        rd(8'h61, v); chk("R11 status A", int'(v), 0);
        rd(8'h44, v); chk("R11 result byte", int'(v), 0);
        chk("R11 irq_a", int'(irq_a), 0);
        chk("R11 irq_b", int'(irq_b), 0);

        // R1 register readback
        set_src(1, 16'h8009, 16'h0000);
        rd(8'h06, v); chk("R1 sel1 lo", int'(v), 8'h09);
        rd(8'h07, v); chk("R1 sel1 hi", int'(v), 8'h80);
        set_src(2, 16'h5A3C, 16'hC3A5);
        rd(8'h0B, v); chk("R1 sel2 hi", int'(v), 8'h5A);
        rd(8'h0C, v); chk("R1 avg2 lo", int'(v), 8'hA5);

        // R3 plain channels 0,3,15; R2 busy the cycle after start
        plan(16'h8009, 16'h0000, "R3");
        wr(8'h12, 8'h20);
        rd(8'h12, v); chk("R2 busy after start", int'(v), 1);
        wait_done(8'h12, "R6");
        rd(8'h12, v); chk("R6 busy clear eoc set", int'(v), 2);
        drain_results();

        // R9/R10 interrupt status and masks
        rd(8'h61, v); chk("R9 status A src1 bit", int'(v), 2);
        rd(8'h63, v); chk("R9 status B src1 bit", int'(v), 2);
        chk("R10 irq_a masked", int'(irq_a), 0);
        wr(8'h62, 8'h00);
        chk("R10 irq_a unmasked", int'(irq_a), 1);
        chk("R10 irq_b still masked", int'(irq_b), 0);
        wr(8'h61, 8'h02);
        rd(8'h61, v); chk("R9 status A cleared", int'(v), 0);
        chk("R10 irq_a after clear", int'(irq_a), 0);
        rd(8'h63, v); chk("R9 status B kept", int'(v), 2);
        wr(8'h63, 8'h02);

        // R4 averaging on channel 7, plain channel 2; R6 restart clears eoc
        set_src(1, 16'h0084, 16'h0080);
        plan(16'h0084, 16'h0080, "R4");
        wr(8'h12, 8'h20);
        rd(8'h12, v); chk("R6 eoc cleared by start", int'(v[1]), 0);
        wait_done(8'h12, "R4");
        drain_results();

        // R4 boundary: all codes at maximum
        force_max = 1;
        set_src(1, 16'h0400, 16'h0400);
        plan(16'h0400, 16'h0400, "R4 max");
        wr(8'h12, 8'h20);
        wait_done(8'h12, "R4 max");
        drain_results();
        force_max = 0;

        // R7 start while busy is ignored
        set_src(1, 16'h0012, 16'h0010);
        plan(16'h0012, 16'h0010, "R7");
        base = total_samples;
        wr(8'h12, 8'h20);
        wr(8'h12, 8'h20);
        wait_done(8'h12, "R7");
        repeat (60) @(negedge clk);
        rd(8'h12, v); chk("R7 no second run", int'(v), 2);
        chk("R7 sample count", total_samples - base, 5);
        drain_results();

        // R8 both sources, source 1 first
        wr(8'h61, 8'h07);
        set_src(1, 16'h0041, 16'h0001);
        set_src(2, 16'h2200, 16'h0200);
        plan(16'h0041, 16'h0001, "R8 src1");
        plan(16'h2200, 16'h0200, "R8 src2");
        wr(8'h12, 8'h20);
        wr(8'h13, 8'h20);
        wait_done(8'h12, "R8 src1");
        rd(8'h13, v); chk("R8 src2 still busy", int'(v), 1);
        wait_done(8'h13, "R8 src2");
        rd(8'h61, v); chk("R9 status A both bits", int'(v), 6);
        chk("R10 irq_a both pending", int'(irq_a), 1);
        drain_results();

        // R12 empty select
        set_src(2, 16'h0000, 16'h0000);
        base = total_samples;
        wr(8'h13, 8'h20);
        wait_done(8'h13, "R12");
        chk("R12 no samples", total_samples - base, 0);
        chk("R3 order queue drained", ord_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule